// File: doc/BRIEF.md
# Multimode 16-bit Timer with Capture and Reload

This block is a general-purpose timer/counter built around a 16-bit count register and a 16-bit reload register. The count register advances on one of three sources: a machine-cycle enable (timer function), falling edges seen on an external count pin (counter function), or a faster state-time enable in the generator mode. A mode decoder picks one of four behaviours. In capture mode, edges on a trigger pin latch the count. In reload-up mode, overflow reloads the count. In up/down mode the trigger pin sets the count direction. In generator mode the block serves as a baud-rate or clock-out source.

Two sticky flags, overflow and external, report events. Their OR drives an interrupt request, and only software clears them. A one-cycle rollover pulse marks every wrap of the count, and a 50% duty clock output toggles on each rollover in clock-out use. A small register port lets software read and write the count, the reload value and the flags. When hardware and software update the same item in the same clock, the hardware update wins.

Top module: `tmr16_multi`

## Requirements
- R1: After a synchronous reset the count, reload, both flags, `irq`, `roll_pulse`, `clk_out` and `reg_rdata` are all zero.
- R2: Timer function (`cnt_sel`=0, not generator mode): with `run`=1 the count goes up by one on each clock where `mc_en`=1. With `run`=0 the count holds.
- R3: Counter function (`cnt_sel`=1): `cnt_pin` is sampled only on clocks with `mc_en`=1. The count goes up by one when a sample of 1 is followed by a sample of 0. Pin changes between samples have no effect.
- R4: Capture mode (`cap_sel`=1): a count of FFFFh wraps to 0000h and sets the overflow flag. With `ext_en`=1, a falling edge of `trig_pin` (sampled like R3) copies the current count into the reload register and sets the external flag.
- R5: Reload-up mode (`cap_sel`=0, `dn_en`=0): at FFFFh a tick loads the reload value and sets the overflow flag. With `ext_en`=1 a `trig_pin` falling edge also loads the reload value and sets the external flag. With `ext_en`=0 the edge is ignored.
- R6: Up/down mode (`dn_en`=1, `cap_sel`=0): `trig_pin`=1 counts up, with FFFFh wrapping to the reload value. `trig_pin`=0 counts down, and a count equal to the reload value wraps to FFFFh. Each wrap sets the overflow flag.
- R7: In up/down mode the external flag inverts on each wrap. Trigger edges do not set it.
- R8: Generator mode is selected by `baud_mode`=1, or by `clk_oe`=1 with `cnt_sel`=0. In this mode the timer ticks on `st_en`. A wrap from FFFFh loads the reload value and never sets the overflow flag. With `ext_en`=1 a `trig_pin` falling edge sets the external flag without reloading.
- R9: With `clk_oe`=1 and `cnt_sel`=0, `clk_out` toggles on every wrap, so it has a 50% duty cycle.
- R10: `irq` equals overflow flag OR external flag. The flags stay set until software writes them, except for the toggle of R7.
- R11: Register map: address 0 is the count, 1 is the reload, 2 holds the flags (bit 0 overflow, bit 1 external), and 3 reads zero. `reg_rdata` returns the addressed item one clock after the address is presented. A write with `reg_we`=1 takes effect at the clock edge.
- R12: If a hardware set of a flag, or a hardware change of the count, falls in the same clock as a software write to that item, the hardware value is kept.
- R13: `roll_pulse` is high for the one clock that follows each wrap (overflow or underflow) in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | Machine-cycle enable: timer tick and pin sample strobe |
| st_en | input | 1 | State-time enable: tick source in generator mode |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | External trigger / direction input |
| run | input | 1 | Counting enable |
| cnt_sel | input | 1 | 1 selects counting of `cnt_pin` falling edges |
| cap_sel | input | 1 | 1 selects capture mode |
| ext_en | input | 1 | Enables trigger-pin edge actions |
| dn_en | input | 1 | Enables up/down counting |
| baud_mode | input | 1 | Selects generator mode |
| clk_oe | input | 1 | Enables the clock output |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external flag |
| irq | output | 1 | Interrupt request |
| roll_pulse | output | 1 | One-clock pulse after each wrap |
| clk_out | output | 1 | Divided 50% duty clock |

## Verification
Random runs of reload-up and capture mode start near FFFFh. They combine random `mc_en` gating with random trigger levels and a random `ext_en`, so the bench can separate tick-driven wraps from trigger-forced reloads and captures, including clocks where both happen at once. Directed sequences cover the rest. Count-pin pulses arrive with and without a sample strobe, which separates edge sampling from level following. An up/down run crosses the reload value and then FFFFh, which separates the compare-to-reload path from the compare-to-all-ones path. Generator runs show that a wrap occurs without an overflow flag, and that trigger edges set the external flag without reloading. Same-clock software writes show that hardware updates take precedence.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    MD_CAPTURE   = 2'd0,
    MD_RELOAD_UP = 2'd1,
    MD_UPDOWN    = 2'd2,
    MD_GENERATOR = 2'd3
  } tmr_mode_e;

  localparam int unsigned REG_AW     = 2;
  localparam logic [REG_AW-1:0] A_COUNT  = 2'd0;
  localparam logic [REG_AW-1:0] A_RELOAD = 2'd1;
  localparam logic [REG_AW-1:0] A_FLAGS  = 2'd2;

  localparam int unsigned PIN_CNT  = 0;
  localparam int unsigned PIN_TRIG = 1;
  localparam int unsigned NPIN     = 2;

  function automatic tmr_mode_e pick_mode(input logic baud, input logic oe,
                                          input logic csel, input logic cap,
                                          input logic dn);
    if (baud || (oe && !csel)) return MD_GENERATOR;
    else if (cap)              return MD_CAPTURE;
    else if (dn)               return MD_UPDOWN;
    else                       return MD_RELOAD_UP;
  endfunction
endpackage

// File: rtl/tmr16_sampler.sv
module tmr16_sampler (
  input  logic clk,
  input  logic rst,
  input  logic smp_en,
  input  logic pin,
  output logic fall
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst)         last_q <= 1'b0;
    else if (smp_en) last_q <= pin;
  end

  // high in the previous sample, low in this one
  assign fall = smp_en & last_q & ~pin;
endmodule

// File: rtl/tmr16_tick.sv
module tmr16_tick
  import tmr16_pkg::*;
(
  input  tmr_mode_e mode,
  input  logic      run,
  input  logic      cnt_sel,
  input  logic      mc_en,
  input  logic      st_en,
  input  logic      cnt_fall,
  output logic      tick
);
  logic base;

  always_comb begin
    if (mode == MD_GENERATOR) base = st_en;
    else                      base = mc_en;
    tick = run & (cnt_sel ? cnt_fall : base);
  end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  tmr_mode_e         mode,
  input  logic              tick,
  input  logic              dir_up,
  input  logic              trig_fall,
  input  logic              ext_en,
  input  logic              clko_en,
  input  logic              sw_we,
  input  logic [REG_AW-1:0] sw_addr,
  input  logic [W-1:0]      sw_wdata,
  output logic [W-1:0]      cnt_q,
  output logic [W-1:0]      rel_q,
  output logic              ovf_q,
  output logic              ext_q,
  output logic              irq_q,
  output logic              roll_q,
  output logic              clko_q
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] cnt_n, rel_n;
  logic         ovf_n, ext_n, clko_n;
  logic         wrap, cnt_hw, capture, ext_set, ext_tog, ext_trig;
  logic         at_top, at_rel, wr_flags;

  assign at_top   = (cnt_q == ALL_ONES);
  assign at_rel   = (cnt_q == rel_q);
  assign ext_trig = ext_en & trig_fall;
  assign wr_flags = sw_we && (sw_addr == A_FLAGS);

  always_comb begin
    cnt_n   = cnt_q;
    wrap    = 1'b0;
    cnt_hw  = 1'b0;
    capture = 1'b0;
    ext_set = 1'b0;
    ext_tog = 1'b0;
    unique case (mode)
      MD_CAPTURE: begin
        if (tick) begin
          cnt_n  = cnt_q + 1'b1;
          cnt_hw = 1'b1;
          wrap   = at_top;
        end
        if (ext_trig) begin
          capture = 1'b1;
          ext_set = 1'b1;
        end
      end
      MD_RELOAD_UP: begin
        if (tick) begin
          cnt_hw = 1'b1;
          wrap   = at_top;
          cnt_n  = at_top ? rel_q : cnt_q + 1'b1;
        end
        if (ext_trig) begin
          cnt_n   = rel_q;
          cnt_hw  = 1'b1;
          ext_set = 1'b1;
        end
      end
      MD_UPDOWN: begin
        if (tick) begin
          cnt_hw = 1'b1;
          if (dir_up) begin
            wrap  = at_top;
            cnt_n = at_top ? rel_q : cnt_q + 1'b1;
          end else begin
            wrap  = at_rel;
            cnt_n = at_rel ? ALL_ONES : cnt_q - 1'b1;
          end
          ext_tog = wrap;
        end
      end
      MD_GENERATOR: begin
        if (tick) begin
          cnt_hw = 1'b1;
          wrap   = at_top;
          cnt_n  = at_top ? rel_q : cnt_q + 1'b1;
        end
        ext_set = ext_trig;
      end
      default: ;
    endcase

    if (sw_we && (sw_addr == A_COUNT) && !cnt_hw) cnt_n = sw_wdata;

    rel_n = rel_q;
    if (capture)                                 rel_n = cnt_q;
    else if (sw_we && (sw_addr == A_RELOAD))     rel_n = sw_wdata;

    ovf_n = (wrap && (mode != MD_GENERATOR)) | (wr_flags ? sw_wdata[0] : ovf_q);

    if (ext_tog)       ext_n = ~ext_q;
    else if (ext_set)  ext_n = 1'b1;
    else if (wr_flags) ext_n = sw_wdata[1];
    else               ext_n = ext_q;

    clko_n = clko_q ^ (wrap && clko_en && (mode == MD_GENERATOR));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      ovf_q  <= 1'b0;
      ext_q  <= 1'b0;
      irq_q  <= 1'b0;
      roll_q <= 1'b0;
      clko_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rel_q  <= rel_n;
      ovf_q  <= ovf_n;
      ext_q  <= ext_n;
      irq_q  <= ovf_n | ext_n;
      roll_q <= wrap;
      clko_q <= clko_n;
    end
  end
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
  import tmr16_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_en,
  input  logic              st_en,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              run,
  input  logic              cnt_sel,
  input  logic              cap_sel,
  input  logic              ext_en,
  input  logic              dn_en,
  input  logic              baud_mode,
  input  logic              clk_oe,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              irq,
  output logic              roll_pulse,
  output logic              clk_out
);
  localparam int unsigned FLAG_PAD = CNT_W - 2;

  tmr_mode_e        mode;
  logic [NPIN-1:0]  pins, falls;
  logic             tick;
  logic [CNT_W-1:0] cnt_q, rel_q, rdata_q;

  assign mode = pick_mode(baud_mode, clk_oe, cnt_sel, cap_sel, dn_en);
  assign pins[PIN_CNT]  = cnt_pin;
  assign pins[PIN_TRIG] = trig_pin;

  for (genvar g = 0; g < NPIN; g++) begin : g_smp
    tmr16_sampler u_smp (
      .clk    (clk),
      .rst    (rst),
      .smp_en (mc_en),
      .pin    (pins[g]),
      .fall   (falls[g])
    );
  end

  tmr16_tick u_tick (
    .mode     (mode),
    .run      (run),
    .cnt_sel  (cnt_sel),
    .mc_en    (mc_en),
    .st_en    (st_en),
    .cnt_fall (falls[PIN_CNT]),
    .tick     (tick)
  );

  tmr16_core #(.W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .tick      (tick),
    .dir_up    (trig_pin),
    .trig_fall (falls[PIN_TRIG]),
    .ext_en    (ext_en),
    .clko_en   (clk_oe & ~cnt_sel),
    .sw_we     (reg_we),
    .sw_addr   (reg_addr),
    .sw_wdata  (reg_wdata),
    .cnt_q     (cnt_q),
    .rel_q     (rel_q),
    .ovf_q     (ovf_flag),
    .ext_q     (ext_flag),
    .irq_q     (irq),
    .roll_q    (roll_pulse),
    .clko_q    (clk_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      unique case (reg_addr)
        A_COUNT:  rdata_q <= cnt_q;
        A_RELOAD: rdata_q <= rel_q;
        A_FLAGS:  rdata_q <= {{FLAG_PAD{1'b0}}, ext_flag, ovf_flag};
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/tmr16_multi_chk.sv
module tmr16_multi_chk
  import tmr16_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cnt_sel,
  input logic              cap_sel,
  input logic              dn_en,
  input logic              baud_mode,
  input logic              clk_oe,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              ovf_flag,
  input logic              ext_flag,
  input logic              irq,
  input logic              roll_pulse,
  input logic              clk_out
);
  logic gen_m, updn_m, fw;
  assign gen_m  = baud_mode | (clk_oe & ~cnt_sel);
  assign updn_m = dn_en & ~cap_sel & ~gen_m;
  assign fw     = reg_we && (reg_addr == A_FLAGS);

  p_irq_or_r10: assert property (@(posedge clk) disable iff (rst)
    irq == (ovf_flag | ext_flag));

  p_ovf_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !fw) |=> ovf_flag);

  p_ext_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (ext_flag && !fw && !updn_m) |=> ext_flag);

  p_no_ovf_gen_r8: assert property (@(posedge clk) disable iff (rst)
    (gen_m && !fw && !ovf_flag) |=> !ovf_flag);

  p_clkout_roll_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_out) |-> roll_pulse);

  p_ovf_roll_r13: assert property (@(posedge clk) disable iff (rst)
    (!ovf_flag && !fw && !gen_m) |=> (ovf_flag -> roll_pulse));
endmodule

bind tmr16_multi tmr16_multi_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_sel    (cnt_sel),
  .cap_sel    (cap_sel),
  .dn_en      (dn_en),
  .baud_mode  (baud_mode),
  .clk_oe     (clk_oe),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .ovf_flag   (ovf_flag),
  .ext_flag   (ext_flag),
  .irq        (irq),
  .roll_pulse (roll_pulse),
  .clk_out    (clk_out)
);

// File: tb/tmr16_multi_bench.sv
module tmr16_multi_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mc_en = 0, st_en = 0, cnt_pin = 0, trig_pin = 0, run = 0;
  logic cnt_sel = 0, cap_sel = 0, ext_en = 0, dn_en = 0, baud_mode = 0, clk_oe = 0;
  logic reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic ovf_flag, ext_flag, irq, roll_pulse, clk_out;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr16_multi u_tmr16_multi (
    .clk(clk), .rst(rst), .mc_en(mc_en), .st_en(st_en), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .run(run), .cnt_sel(cnt_sel), .cap_sel(cap_sel),
    .ext_en(ext_en), .dn_en(dn_en), .baud_mode(baud_mode), .clk_oe(clk_oe),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq),
    .roll_pulse(roll_pulse), .clk_out(clk_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    step();
    d = reg_rdata;
  endtask

  task automatic trig_fall();
    trig_pin = 1; mc_en = 1; step();
    trig_pin = 0; step();
    mc_en = 0;
  endtask

  // bench model for reload-up / capture random runs
  logic [15:0] m_cnt, m_rel;
  logic m_ovf, m_ext, m_tsmp;

  function automatic logic [15:0] next_cnt(input logic cap, input logic tk,
                                           input logic frc, input logic [15:0] c,
                                           input logic [15:0] r);
    logic [15:0] v;
    v = c;
    if (tk) v = (c == 16'hFFFF && !cap) ? r : c + 16'd1;
    if (frc && !cap) v = r;
    return v;
  endfunction

  initial begin
    logic [15:0] rv;
    void'($urandom(32'd2718));
    repeat (3) step();
    rst = 0;
    step();
    // R1
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 ext", ext_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 clk_out", clk_out, 0);
    chk("R1 roll", roll_pulse, 0);
    rd(2'd0, rv); chk("R1 count", rv, 16'h0000);
    rd(2'd1, rv); chk("R1 reload", rv, 16'h0000);

    // R2 timer function, reload-up mode
    run = 1; mc_en = 1; repeat (5) step();
    mc_en = 0; repeat (3) step();
    run = 0; mc_en = 1; repeat (2) step();
    mc_en = 0;
    rd(2'd0, rv); chk("R2 count gated", rv, 16'd5);

    // R3 counter function
    wr(2'd0, 16'd0);
    cnt_sel = 1; run = 1;
    mc_en = 1; cnt_pin = 1; step();
    cnt_pin = 0; step();
    cnt_pin = 1; step();
    cnt_pin = 0; step();
    cnt_pin = 0; step();
    cnt_pin = 1; step();
    cnt_pin = 0; step();
    cnt_pin = 1; step();
    mc_en = 0; cnt_pin = 0; step();
    mc_en = 1; cnt_pin = 1; step();
    mc_en = 0; run = 0;
    rd(2'd0, rv); chk("R3 edge count", rv, 16'd3);
    cnt_sel = 0; cnt_pin = 0;

    // R4 capture mode
    cap_sel = 1; ext_en = 1;
    wr(2'd0, 16'hFFFE); wr(2'd2, 16'h0000);
    run = 1; mc_en = 1; trig_pin = 1; step();
    trig_pin = 0; step();
    run = 0; mc_en = 0;
    chk("R4 ovf set on wrap", ovf_flag, 1);
    chk("R4 ext set on capture", ext_flag, 1);
    chk("R13 roll after wrap", roll_pulse, 1);
    chk("R10 irq", irq, 1);
    step();
    chk("R13 roll one cycle", roll_pulse, 0);
    repeat (3) step();
    chk("R10 ovf sticky", ovf_flag, 1);
    rd(2'd1, rv); chk("R4 captured value", rv, 16'hFFFF);
    rd(2'd0, rv); chk("R4 count wrapped", rv, 16'h0000);
    wr(2'd2, 16'h0000);
    chk("R10 irq cleared", irq, 0);
    cap_sel = 0; ext_en = 0;

    // R5 reload-up
    wr(2'd1, 16'h1234); wr(2'd0, 16'hFFFF);
    run = 1; mc_en = 1; step();
    run = 0; mc_en = 0;
    chk("R5 ovf", ovf_flag, 1);
    rd(2'd0, rv); chk("R5 reload on overflow", rv, 16'h1234);
    wr(2'd2, 16'h0000); wr(2'd0, 16'h0005);
    trig_fall();
    chk("R5 ignored ext", ext_flag, 0);
    rd(2'd0, rv); chk("R5 ignored count", rv, 16'h0005);
    ext_en = 1;
    trig_fall();
    chk("R5 forced ext", ext_flag, 1);
    chk("R5 forced no ovf", ovf_flag, 0);
    rd(2'd0, rv); chk("R5 forced reload", rv, 16'h1234);
    ext_en = 0;

    // R6 / R7 up/down
    dn_en = 1;
    wr(2'd2, 16'h0000); wr(2'd1, 16'h0010); wr(2'd0, 16'h0012);
    trig_pin = 0; run = 1; mc_en = 1; repeat (3) step();
    run = 0; mc_en = 0;
    chk("R6 underflow ovf", ovf_flag, 1);
    chk("R7 ext toggled on", ext_flag, 1);
    rd(2'd0, rv); chk("R6 underflow loads FFFF", rv, 16'hFFFF);
    trig_pin = 1; run = 1; mc_en = 1; step();
    run = 0; mc_en = 0;
    chk("R7 ext toggled off", ext_flag, 0);
    chk("R6 ovf held", ovf_flag, 1);
    rd(2'd0, rv); chk("R6 up wrap to reload", rv, 16'h0010);
    trig_pin = 0; mc_en = 1; step(); mc_en = 0;
    chk("R7 trigger edge no set", ext_flag, 0);
    dn_en = 0;

    // R8 generator
    baud_mode = 1; ext_en = 1;
    wr(2'd2, 16'h0000); wr(2'd1, 16'hFFFD); wr(2'd0, 16'hFFFE);
    run = 1; st_en = 1; step(); step();
    chk("R13 roll in generator", roll_pulse, 1);
    chk("R8 no ovf", ovf_flag, 0);
    step();
    chk("R13 roll drops", roll_pulse, 0);
    run = 0; st_en = 0;
    trig_fall();
    chk("R8 trig sets ext", ext_flag, 1);
    rd(2'd0, rv); chk("R8 trig no reload", rv, 16'hFFFE);
    baud_mode = 0; ext_en = 0;

    // R9 clock-out
    clk_oe = 1;
    wr(2'd2, 16'h0000); wr(2'd1, 16'hFFFE); wr(2'd0, 16'hFFFE);
    run = 1; st_en = 1;
    for (int k = 1; k <= 6; k++) begin
      step();
      if (k % 2 == 0) chk("R9 clk_out toggle", clk_out, (k % 4 == 2) ? 1 : 0);
    end
    run = 0; st_en = 0;
    chk("R8 clock-out no ovf", ovf_flag, 0);
    clk_oe = 0;

    // R12 hardware wins
    wr(2'd1, 16'h0200); wr(2'd0, 16'hFFFF); wr(2'd2, 16'h0000);
    run = 1; mc_en = 1; reg_we = 1; reg_addr = 2'd2; reg_wdata = 16'h0000;
    step();
    run = 0; mc_en = 0; reg_we = 0;
    chk("R12 flag write loses", ovf_flag, 1);
    wr(2'd0, 16'h0005);
    run = 1; mc_en = 1; reg_we = 1; reg_addr = 2'd0; reg_wdata = 16'h0100;
    step();
    run = 0; mc_en = 0; reg_we = 0;
    rd(2'd0, rv); chk("R12 count write loses", rv, 16'h0006);

    // R11 read latency and map
    reg_addr = 2'd1; #1;
    chk("R11 rdata before edge", reg_rdata, 16'h0006);
    step();
    chk("R11 rdata after edge", reg_rdata, 16'h0200);
    rd(2'd2, rv); chk("R11 flag bits", rv, 16'h0001);
    rd(2'd3, rv); chk("R11 unused addr", rv, 16'h0000);

    // random reload-up (b=0) and capture (b=1)
    for (int b = 0; b < 2; b++) begin
      logic mc, tp, ee, fall;
      logic [15:0] old;
      cap_sel = logic'(b);
      m_rel = 16'hFF00 | 16'($urandom % 256);
      wr(2'd1, m_rel); wr(2'd0, 16'hFFF0); wr(2'd2, 16'h0000);
      trig_pin = 0; mc_en = 1; step();
      m_cnt = 16'hFFF0; m_ovf = 0; m_ext = 0; m_tsmp = 0;
      reg_addr = 2'd0; run = 1;
      for (int i = 0; i < 300; i++) begin
        mc = logic'($urandom % 2);
        tp = logic'(($urandom % 4) != 0);
        ee = logic'($urandom % 2);
        mc_en = mc; trig_pin = tp; ext_en = ee;
        fall = mc && m_tsmp && !tp;
        old = m_cnt;
        if (mc && old == 16'hFFFF) m_ovf = 1;
        if (fall && ee) begin
          m_ext = 1;
          if (b == 1) m_rel = old;
        end
        m_cnt = next_cnt(logic'(b), mc, fall && ee, old, m_rel);
        if (mc) m_tsmp = tp;
        step();
        chk(b == 0 ? "R5 random count" : "R4 random count", reg_rdata, old);
        chk(b == 0 ? "R5 random ovf" : "R4 random ovf", ovf_flag, m_ovf);
        chk(b == 0 ? "R5 random ext" : "R4 random ext", ext_flag, m_ext);
      end
      run = 0; mc_en = 0; ext_en = 0;
      rd(2'd1, rv); chk("R4 R5 random reload reg", rv, m_rel);
    end
    cap_sel = 0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule